// File: doc/BRIEF.md
# Cassette Tape Transport Controller

This block runs the motor of a digital cassette transport and turns the transport's read-head output into bytes. The host issues one of five motion commands: stop, play forward, play reverse, wind forward or wind reverse. The controller drives three active-high motor lines: forward, reverse and fast. It never drives forward and reverse together. When the host asks for the opposite direction while the tape is moving, it puts a short all-low gap between the two directions.

The read head delivers a clock line and a data line. The clock speeds up as the tape runs, so the block uses no baud-rate timing. Both head lines pass through a synchroniser. One data bit is taken on each rising edge of the synchronised clock, most significant bit first. After every eighth bit the byte is presented with a one-cycle strobe.

Two sense inputs report cassette presence and clear leader in front of the optical sensor. The transport stops on its own, and raises an end-of-tape flag, in two cases: the cassette goes away, or leader appears after data tape has passed the sensor.

Top module: `tape_xport_ctrl`

## Requirements
- R1: `mot_fwd_o` and `mot_rev_o` are never high in the same cycle, whatever the command sequence.
- R2: A command is taken on a rising clock edge where `cmd_valid_i` is high, and the motor outputs change on that same edge. Codes on `cmd_code_i` are: 0 stop (all low), 1 play forward (forward only), 2 play reverse (reverse only), 3 wind forward (forward and fast), 4 wind reverse (reverse and fast). Codes 5 to 7 change nothing. A new speed in the current direction takes effect at once.
- R3: A motion command issued while the motor is idle is ignored unless the synchronised cassette-sense input is high.
- R4: A command for the opposite direction while moving drives all motor lines low for `REV_GAP` cycles (default 1), then the new direction. A stop command during the gap ends it at idle.
- R5: If the cassette-sense input falls while the motor is moving or in the gap, all motor lines go low on the third clock edge after the input changes, and `eot_o` goes high.
- R6: Leader seen when the motor starts does not stop it. Leader that appears after a data (non-leader) cycle has been seen during the run stops the motor three edges after the input change and sets `eot_o`.
- R7: `eot_o` clears when a motion command is accepted from idle. A stop command leaves it unchanged.
- R8: While a motor direction line is high, each rising edge of the synchronised head clock shifts in the synchronised data level (high = 1), most significant bit first. The eighth bit loads `byte_o` and pulses `byte_vld_o` for one cycle, three edges after the raw clock rise.
- R9: Bytes are assembled correctly whatever the head-clock period, including a period that shrinks within one byte down to two system cycles.
- R10: While no direction line is high, no bits are taken and the bit count is cleared, so a partial byte is discarded and the next run starts a fresh byte.
- R11: After reset all motor lines, `eot_o`, `byte_vld_o` and `byte_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (see R2) |
| cass_present_i | input | 1 | High when a cassette is inserted and the lid is closed (asynchronous) |
| leader_i | input | 1 | High when clear leader is at the sensor (asynchronous) |
| head_clk_i | input | 1 | Tape-supplied bit clock (asynchronous) |
| head_dat_i | input | 1 | Tape data bit (asynchronous) |
| mot_fwd_o | output | 1 | Forward motor drive, active high |
| mot_rev_o | output | 1 | Reverse motor drive, active high |
| mot_fast_o | output | 1 | Fast wind select, active high |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| eot_o | output | 1 | Set when the motor was stopped by leader or cassette loss |

## Verification
The assertions assume the head clock stays high and low for at least one system cycle each, so that rising edges after synchronisation are at least two cycles apart and the byte strobe can never be held high. They also assume the data line is stable around each clock rise, long enough to pass through the same synchroniser depth. The stimulus sets data while the clock is low and holds every clock phase for one or more whole cycles, shrinking the period down to that minimum. Sense inputs and commands change only on the falling clock edge.

// File: rtl/tape_pkg.sv
package tape_pkg;

  typedef enum logic [2:0] {
    CMD_STOP     = 3'd0,
    CMD_PLAY_FWD = 3'd1,
    CMD_PLAY_REV = 3'd2,
    CMD_WIND_FWD = 3'd3,
    CMD_WIND_REV = 3'd4
  } tape_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } mot_state_e;

  typedef struct packed {
    logic fwd;
    logic rev;
    logic fast;
  } motor_drive_t;

endpackage

// File: rtl/tape_rst_sync.sv
module tape_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/tape_sync.sv
module tape_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tape_motor.sv
module tape_motor
  import tape_pkg::*;
#(
  parameter int REV_GAP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_code,
  input  logic         cass_s,
  input  logic         leader_s,
  output motor_drive_t drive,
  output logic         eot
);
  localparam int GAP_W = (REV_GAP < 2) ? 1 : $clog2(REV_GAP);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(REV_GAP - 1);

  mot_state_e   state_q, state_n;
  logic         dir_rev_q, dir_rev_n;
  logic         fast_q, fast_n;
  logic         pend_rev_q, pend_rev_n;
  logic         pend_fast_q, pend_fast_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic         seen_q, seen_n;
  logic         eot_q, eot_n;
  motor_drive_t out_q, out_n;

  logic is_move, is_stop, want_rev, want_fast, fault;

  always_comb begin
    is_stop   = cmd_valid && (cmd_code == CMD_STOP);
    is_move   = cmd_valid && ((cmd_code == CMD_PLAY_FWD) || (cmd_code == CMD_PLAY_REV) ||
                              (cmd_code == CMD_WIND_FWD) || (cmd_code == CMD_WIND_REV));
    want_rev  = (cmd_code == CMD_PLAY_REV) || (cmd_code == CMD_WIND_REV);
    want_fast = (cmd_code == CMD_WIND_FWD) || (cmd_code == CMD_WIND_REV);
    fault     = !cass_s || (leader_s && seen_q);
  end

  always_comb begin
    state_n     = state_q;
    dir_rev_n   = dir_rev_q;
    fast_n      = fast_q;
    pend_rev_n  = pend_rev_q;
    pend_fast_n = pend_fast_q;
    gap_n       = gap_q;
    seen_n      = seen_q;
    eot_n       = eot_q;
    case (state_q)
      ST_IDLE: begin
        if (is_move && cass_s) begin
          state_n   = ST_RUN;
          dir_rev_n = want_rev;
          fast_n    = want_fast;
          eot_n     = 1'b0;
          seen_n    = 1'b0;
        end
      end
      default: begin
        if (fault) begin
          state_n = ST_IDLE;
          eot_n   = 1'b1;
          seen_n  = 1'b0;
        end else if (is_stop) begin
          state_n = ST_IDLE;
        end else begin
          if (!leader_s) seen_n = 1'b1;
          if (state_q == ST_RUN) begin
            if (is_move) begin
              if (want_rev == dir_rev_q) begin
                fast_n = want_fast;
              end else begin
                state_n     = ST_GAP;
                pend_rev_n  = want_rev;
                pend_fast_n = want_fast;
                gap_n       = GAP_LOAD;
              end
            end
          end else begin
            if (is_move) begin
              pend_rev_n  = want_rev;
              pend_fast_n = want_fast;
            end
            if (gap_q == '0) begin
              state_n   = ST_RUN;
              dir_rev_n = pend_rev_n;
              fast_n    = pend_fast_n;
            end else begin
              gap_n = gap_q - 1'b1;
            end
          end
        end
      end
    endcase
    out_n.fwd  = (state_n == ST_RUN) && !dir_rev_n;
    out_n.rev  = (state_n == ST_RUN) &&  dir_rev_n;
    out_n.fast = (state_n == ST_RUN) &&  fast_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dir_rev_q   <= 1'b0;
      fast_q      <= 1'b0;
      pend_rev_q  <= 1'b0;
      pend_fast_q <= 1'b0;
      gap_q       <= '0;
      seen_q      <= 1'b0;
      eot_q       <= 1'b0;
      out_q       <= '0;
    end else begin
      state_q     <= state_n;
      dir_rev_q   <= dir_rev_n;
      fast_q      <= fast_n;
      pend_rev_q  <= pend_rev_n;
      pend_fast_q <= pend_fast_n;
      gap_q       <= gap_n;
      seen_q      <= seen_n;
      eot_q       <= eot_n;
      out_q       <= out_n;
    end
  end

  assign drive = out_q;
  assign eot   = eot_q;

  // R1: direction interlock on the registered drive lines
  a_r1_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_q.fwd && out_q.rev));

  // R4: no direct flip from one direction to the other
  a_r4_fwd_then_not_rev: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.fwd |=> !out_q.rev);
  a_r4_rev_then_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.rev |=> !out_q.fwd);

  // R2: fast is only driven together with a direction
  a_r2_fast_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.fast |-> (out_q.fwd || out_q.rev));

  // R5: losing the cassette while moving stops the motor and flags end of tape
  a_r5_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!cass_s && (state_q != ST_IDLE)) |=> ((out_q == '0) && eot_q));

  // R7: an accepted start clears the flag
  a_r7_start_clears_eot: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && is_move && cass_s) |=> !eot_q);

  // R3: no start without a cassette
  a_r3_no_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !cass_s) |=> !(out_q.fwd || out_q.rev));
endmodule

// File: rtl/tape_packer.sv
module tape_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hclk_s,
  input  logic              hdat_s,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int CNT_W = (BYTE_W < 2) ? 1 : $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              prev_q;
  logic [BYTE_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              vld_q, vld_n;
  logic              rise;
  logic [BYTE_W-1:0] shifted;

  assign rise    = hclk_s && !prev_q;
  assign shifted = {shift_q[BYTE_W-2:0], hdat_s};

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    byte_n  = byte_q;
    vld_n   = 1'b0;
    if (!run) begin
      shift_n = '0;
      cnt_n   = '0;
    end else if (rise) begin
      shift_n = shifted;
      if (cnt_q == LAST_BIT) begin
        cnt_n  = '0;
        byte_n = shifted;
        vld_n  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      prev_q  <= hclk_s;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      byte_q  <= byte_n;
      vld_q   <= vld_n;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;

  // R8: the strobe lasts a single cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R10: no motor, no partial byte kept
  a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((cnt_q == '0) && !vld_q));
endmodule

// File: rtl/tape_xport_ctrl.sv
module tape_xport_ctrl
  import tape_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REV_GAP     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_code_i,
  input  logic              cass_present_i,
  input  logic              leader_i,
  input  logic              head_clk_i,
  input  logic              head_dat_i,
  output logic              mot_fwd_o,
  output logic              mot_rev_o,
  output logic              mot_fast_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              eot_o
);
  localparam int N_SENSE = 4;

  logic               srst_n;
  logic [N_SENSE-1:0] raw_in, sync_in;
  motor_drive_t       drive;

  tape_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign raw_in = {head_dat_i, head_clk_i, leader_i, cass_present_i};

  tape_sync #(.WIDTH(N_SENSE), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  tape_motor #(.REV_GAP(REV_GAP)) u_motor (
    .clk       (clk),
    .rst_n     (srst_n),
    .cmd_valid (cmd_valid_i),
    .cmd_code  (cmd_code_i),
    .cass_s    (sync_in[0]),
    .leader_s  (sync_in[1]),
    .drive     (drive),
    .eot       (eot_o)
  );

  tape_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst_n      (srst_n),
    .run        (drive.fwd || drive.rev),
    .hclk_s     (sync_in[2]),
    .hdat_s     (sync_in[3]),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );

  assign mot_fwd_o  = drive.fwd;
  assign mot_rev_o  = drive.rev;
  assign mot_fast_o = drive.fast;
endmodule

// File: tb/tb_tape_xport_ctrl.sv
`timescale 1ns/1ps
module tb_tape_xport_ctrl;
  localparam int REV_GAP = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_code;
  logic       cass, lead, hclk, hdat;
  logic       fwd, rev, fast, vld, eot;
  logic [7:0] byt;

  always #2.5 clk = ~clk;

  tape_xport_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .cass_present_i(cass), .leader_i(lead), .head_clk_i(hclk), .head_dat_i(hdat),
    .mot_fwd_o(fwd), .mot_rev_o(rev), .mot_fast_o(fast),
    .byte_o(byt), .byte_vld_o(vld), .eot_o(eot)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, n_bytes = 0;
  bit done = 0;
  logic [7:0] got_byte;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int         m_mode;  // 0 idle, 1 run, 2 gap
  bit         m_dir, m_fst, m_pdir, m_pfst, m_seen, m_eot, m_prev, m_vld;
  bit         m_fwd, m_rev, m_fast;
  int         m_gc, m_cnt;
  bit [7:0]   m_sh, m_byte;
  bit         qc[$], ql[$], qk[$], qd[$];

  always @(posedge clk) begin
    bit cs, ld, ck, dt, mv, wr, wf, run;
    if (!rst_n) begin
      m_mode = 0; m_dir = 0; m_fst = 0; m_pdir = 0; m_pfst = 0; m_seen = 0;
      m_eot = 0; m_prev = 0; m_vld = 0; m_fwd = 0; m_rev = 0; m_fast = 0;
      m_gc = 0; m_cnt = 0; m_sh = 0; m_byte = 0;
      qc = '{0, 0}; ql = '{0, 0}; qk = '{0, 0}; qd = '{0, 0};
    end else begin
      cs = qc[0]; ld = ql[0]; ck = qk[0]; dt = qd[0];
      run = m_fwd | m_rev;
      m_vld = 0;
      if (!run) begin m_cnt = 0; m_sh = 0; end
      else if (ck && !m_prev) begin
        m_sh = {m_sh[6:0], dt};
        m_cnt++;
        if (m_cnt == 8) begin m_byte = m_sh; m_vld = 1; m_cnt = 0; end
      end
      m_prev = ck;
      mv = cmd_valid && (cmd_code >= 1) && (cmd_code <= 4);
      wr = (cmd_code == 2) || (cmd_code == 4);
      wf = (cmd_code == 3) || (cmd_code == 4);
      if (m_mode == 0) begin
        if (mv && cs) begin m_mode = 1; m_dir = wr; m_fst = wf; m_eot = 0; m_seen = 0; end
      end else if (!cs || (ld && m_seen)) begin
        m_mode = 0; m_eot = 1; m_seen = 0;
      end else if (cmd_valid && cmd_code == 0) begin
        m_mode = 0;
      end else begin
        if (!ld) m_seen = 1;
        if (m_mode == 1) begin
          if (mv) begin
            if (wr == m_dir) m_fst = wf;
            else begin m_mode = 2; m_pdir = wr; m_pfst = wf; m_gc = REV_GAP - 1; end
          end
        end else begin
          if (mv) begin m_pdir = wr; m_pfst = wf; end
          if (m_gc == 0) begin m_mode = 1; m_dir = m_pdir; m_fst = m_pfst; end
          else m_gc--;
        end
      end
      m_fwd = (m_mode == 1) && !m_dir;
      m_rev = (m_mode == 1) && m_dir;
      m_fast = (m_mode == 1) && m_fst;
      void'(qc.pop_front()); qc.push_back(cass);
      void'(ql.pop_front()); ql.push_back(lead);
      void'(qk.pop_front()); qk.push_back(hclk);
      void'(qd.pop_front()); qd.push_back(hdat);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 interlock", {31'd0, fwd & rev}, 32'd0);
      check("R2 motor lines", {29'd0, fwd, rev, fast}, {29'd0, m_fwd, m_rev, m_fast});
      check("R5 eot flag", {31'd0, eot}, {31'd0, m_eot});
      check("R8 byte strobe", {31'd0, vld}, {31'd0, m_vld});
      if (vld) begin
        check("R9 byte value", {24'd0, byt}, {24'd0, m_byte});
        got_byte = byt;
        n_bytes++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [2:0] c);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0; cmd_code = 3'd0;
  endtask

  task automatic send_bit(input bit b, input int half);
    hdat = b; hclk = 0;
    wait_cyc(half);
    hclk = 1;
    wait_cyc(half);
  endtask

  task automatic send_byte(input bit [7:0] v, input int half);
    for (int i = 7; i >= 0; i--) send_bit(v[i], half);
    hclk = 0;
    wait_cyc(4);
  endtask

  initial begin
    int nb;
    rst_n = 0; cmd_valid = 0; cmd_code = 0; cass = 0; lead = 0; hclk = 0; hdat = 0;
    got_byte = 0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(5);
    // R11 reset state
    check("R11 reset outputs", {26'd0, fwd, rev, fast, vld, eot, |byt}, 32'd0);

    // R3 no cassette: start ignored
    send_cmd(3'd1);
    check("R3 start without cassette", {29'd0, fwd, rev, fast}, 32'd0);

    // R6 start on leader must not stop
    cass = 1; lead = 1;
    wait_cyc(3);
    send_cmd(3'd1);
    check("R2 play forward", {29'd0, fwd, rev, fast}, 32'b100);
    wait_cyc(5);
    check("R6 leader at start keeps running", {31'd0, fwd}, 32'd1);
    lead = 0;
    wait_cyc(3);

    // R8 byte capture MSB first
    send_byte(8'hA5, 3);
    check("R8 captured byte", {24'd0, got_byte}, 32'hA5);

    // R2 wind forward, then ignored code
    send_cmd(3'd3);
    check("R2 wind forward", {29'd0, fwd, rev, fast}, 32'b101);
    send_cmd(3'd6);
    check("R2 unused code ignored", {29'd0, fwd, rev, fast}, 32'b101);

    // R9 shrinking period within one byte
    begin
      bit [7:0] v = 8'h3C;
      int hs[8] = '{4, 4, 3, 3, 2, 2, 1, 1};
      for (int i = 0; i < 8; i++) send_bit(v[7-i], hs[i]);
      hclk = 0;
      wait_cyc(4);
    end
    check("R9 byte at rising rate", {24'd0, got_byte}, 32'h3C);

    // R4 reversal gap
    send_cmd(3'd2);
    check("R4 gap all low", {29'd0, fwd, rev, fast}, 32'd0);
    wait_cyc(1);
    check("R4 new direction after gap", {29'd0, fwd, rev, fast}, 32'b010);

    // R10 partial byte discarded by stop
    send_bit(1, 2); send_bit(1, 2); send_bit(1, 2);
    hclk = 0; wait_cyc(3);
    send_cmd(3'd0);
    check("R2 stop", {29'd0, fwd, rev, fast}, 32'd0);
    nb = n_bytes;
    send_byte(8'hFF, 2);
    check("R10 no capture while stopped", n_bytes, nb);
    send_cmd(3'd1);
    send_byte(8'h5A, 2);
    check("R10 fresh byte after restart", {24'd0, got_byte}, 32'h5A);

    // R5 cassette loss
    cass = 0;
    wait_cyc(3);
    check("R5 loss stops motor", {29'd0, fwd, rev, fast}, 32'd0);
    check("R5 loss sets eot", {31'd0, eot}, 32'd1);
    send_cmd(3'd0);
    check("R7 stop keeps eot", {31'd0, eot}, 32'd1);
    cass = 1;
    wait_cyc(3);
    send_cmd(3'd4);
    check("R7 start clears eot", {31'd0, eot}, 32'd0);
    check("R2 wind reverse", {29'd0, fwd, rev, fast}, 32'b011);

    // R6 leader after data stops
    wait_cyc(6);
    lead = 1;
    wait_cyc(2);
    check("R6 still moving before sync", {31'd0, rev}, 32'd1);
    wait_cyc(1);
    check("R6 leader stops motor", {29'd0, fwd, rev, fast}, 32'd0);
    check("R6 leader sets eot", {31'd0, eot}, 32'd1);
    wait_cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule